// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is an I2C target that sits in front of an 8-bit-addressed register space. A controller first sends the 7-bit device address. If the address matches and the write bit is set, the controller sends one byte that loads an internal register pointer. Every further byte in that transaction is stored at the pointer, and the pointer then steps forward. To read, the controller sets the pointer the same way, issues a repeated START with the read bit, and clocks out bytes. The target keeps sending the byte at the next pointer value for as long as the controller acknowledges.

Reads and writes share one pointer. It advances after every byte in either direction and wraps at the top of the space, so a whole register range can be swept in one transaction. A read that starts without a new pointer byte continues where the last access left off. The block drives the bus only through an open-drain enable for SDA. It connects to the register file through an address, write data, a single-cycle write strobe and read data. SCL and SDA must arrive already synchronised to `clk`. Clock stretching is not supported.

Top module: `i2c_regport`

## Requirements
- R1: When the first byte after a START carries the device address (bits 7:1, default 2Ah), the target pulls SDA low during the ninth SCL clock. This holds for both values of the direction bit (bit 0: 0 = write, 1 = read).
- R2: A first byte carrying any other address gets no acknowledge. All later bytes get no acknowledge and cause no register write until the next START.
- R3: After a write-direction address, the second byte loads the pointer. Each further byte produces `reg_we` for exactly one clock, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. This happens after the byte's eighth SCL falling edge.
- R4: The pointer steps by one after each data byte written or read. Writes and reads share the pointer, so a read with no new pointer byte continues from the last position.
- R5: Every byte after a matching write-direction address is acknowledged by the target.
- R6: After a repeated START with a matching read-direction address, the target sends the register at the pointer, MSB first. SDA changes only while SCL is low.
- R7: A controller ACK (SDA low in the ninth clock) makes the target send the next register. On a NACK the target releases SDA and sends nothing more until the next START.
- R8: The pointer wraps from FFh to 00h in both directions.
- R9: A START or STOP in the middle of a byte abandons that byte without a register write and resets the bit count. A START begins a new address phase at once.
- R10: A read byte is captured from `reg_rdata` when its first bit goes out. Changing the register while the byte is being sent does not alter the byte on the bus.
- R11: Out of reset, and after any STOP, SDA is released and `reg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level as seen on the bus |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_addr | output | AW | Register pointer, used as the register-file address |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register-file read data at `reg_addr` |

## Verification
Every result appears within two clocks of the SCL or SDA edge that causes it. The line levels are captured on the clock edge after they change, and `sda_oe` and `reg_we` update on the next edge. The bench therefore moves SCL and SDA only on falling clock edges and holds each quarter of an SCL period for ten clocks. It reads ACKs and data bits halfway through the SCL high phase, well after any change the target makes. Register contents are compared only after the write strobe has been taken by the bench's register model, and the release of SDA after a NACK is checked once that SCL low phase has settled.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEVADDR,
    PH_REGADDR,
    PH_WRITE,
    PH_READ
  } phase_t;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_ptr_counter.sv
module i2c_ptr_counter #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end

  // R4 R8: one step per increment, wrapping at the top of the space
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> ptr == AW'($past(ptr) + 1'b1));
endmodule

// File: rtl/i2c_tx_shifter.sv
module i2c_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  output logic         bit_o
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)        sreg <= '1;
    else if (load)  sreg <= load_val;
    else if (shift) sreg <= {sreg[W-2:0], 1'b1};
  end

  assign bit_o = sreg[W-1];
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         AW       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic scl_rise, scl_fall, start_det, stop_det;
  phase_t phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sreg;
  logic ack_slot, ack_drv, tx_en, send_next;
  logic byte_done, slot_end;
  logic ptr_load, ptr_inc, tx_load, tx_shift, tx_bit;

  i2c_line_events u_events (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ptr_counter #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(AW'(rx_sreg)),
    .inc(ptr_inc), .ptr(reg_addr)
  );

  i2c_tx_shifter #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .shift(tx_shift),
    .load_val(reg_rdata), .bit_o(tx_bit)
  );

  assign byte_done = scl_fall && !ack_slot && (bit_cnt == CNT_W'(BYTE_W))
                     && (phase != PH_IDLE);
  assign slot_end  = scl_fall && ack_slot;

  always_comb begin
    ptr_load = 1'b0;
    ptr_inc  = reg_we;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    if (!start_det && !stop_det) begin
      if (byte_done && phase == PH_REGADDR) ptr_load = 1'b1;
      if (byte_done && phase == PH_READ)    ptr_inc  = 1'b1;
      if (slot_end && phase == PH_READ && send_next) tx_load = 1'b1;
      if (scl_fall && !ack_slot && phase == PH_READ && tx_en &&
          bit_cnt != '0 && bit_cnt < CNT_W'(BYTE_W))
        tx_shift = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      rx_sreg   <= '0;
      ack_slot  <= 1'b0;
      ack_drv   <= 1'b0;
      tx_en     <= 1'b0;
      send_next <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det || stop_det) begin
        phase     <= start_det ? PH_DEVADDR : PH_IDLE;
        bit_cnt   <= '0;
        ack_slot  <= 1'b0;
        ack_drv   <= 1'b0;
        tx_en     <= 1'b0;
        send_next <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !ack_slot && bit_cnt < CNT_W'(BYTE_W)) begin
          rx_sreg <= {rx_sreg[BYTE_W-2:0], sda_i};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (scl_rise && ack_slot && phase == PH_READ && !ack_drv)
          send_next <= ~sda_i;
        if (byte_done) begin
          ack_slot <= 1'b1;
          unique case (phase)
            PH_DEVADDR: begin
              if (rx_sreg[7:1] == DEV_ADDR) begin
                ack_drv   <= 1'b1;
                phase     <= rx_sreg[0] ? PH_READ : PH_REGADDR;
                send_next <= rx_sreg[0];
              end else begin
                phase    <= PH_IDLE;
                ack_slot <= 1'b0;
                bit_cnt  <= '0;
              end
            end
            PH_REGADDR: begin
              ack_drv <= 1'b1;
              phase   <= PH_WRITE;
            end
            PH_WRITE: begin
              ack_drv   <= 1'b1;
              reg_we    <= 1'b1;
              reg_wdata <= rx_sreg;
            end
            PH_READ: begin
              tx_en     <= 1'b0;
              send_next <= 1'b0;
            end
            default: ;
          endcase
        end
        if (slot_end) begin
          ack_slot <= 1'b0;
          ack_drv  <= 1'b0;
          bit_cnt  <= '0;
          if (phase == PH_READ) begin
            if (send_next) tx_en <= 1'b1;
            else           phase <= PH_IDLE;
          end
        end
      end
    end
  end

  assign sda_oe = ack_drv | (tx_en & ~tx_bit);

  // R1 R5: the acknowledge drive stays inside the ninth clock
  ack_window_chk: assert property (@(posedge clk) disable iff (rst)
    ack_drv |-> ack_slot);

  // R3: the write strobe lasts a single clock
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R3: writes only happen in the data phase of a write transaction
  we_phase_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> phase == PH_WRITE);

  // R9
  start_abort_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (bit_cnt == '0 && !ack_slot && phase == PH_DEVADDR));

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (phase == PH_IDLE && !sda_oe && !reg_we));

  // R2 R7: an idle target never pulls the bus
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !sda_oe);
endmodule

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] mem [256];
  int we_count = 0;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_regport #(.DEV_ADDR(DEV), .AW(8)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    acked = ~sda_bus;
    qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic recv_byte(input logic mack, input bit poke, input int paddr,
                           input logic [7:0] pval, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait(); scl_m = 1'b1; qwait();
      b[i] = sda_bus;
      if (poke && i == 7) mem[paddr] = pval;
      qwait(); scl_m = 1'b0;
    end
    qwait(); sda_m = ~mack; qwait(); scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait(); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p, input bit close);
    logic a;
    i2c_start();
    send_byte({DEV, 1'b0}, a); check("R1 write address ack", a, 1);
    send_byte(p, a);           check("R5 pointer byte ack", a, 1);
    if (close) i2c_stop();
  endtask

  task automatic t_reset();
    check("R11 sda released after reset", sda_oe, 0);
    check("R11 no strobe after reset", reg_we, 0);
  endtask

  task automatic t_write_burst();
    logic a; int c0 = we_count;
    set_ptr(8'h10, 1'b0);
    send_byte(8'hA1, a); check("R5 data ack 0", a, 1);
    send_byte(8'hB2, a); check("R5 data ack 1", a, 1);
    send_byte(8'hC3, a); check("R5 data ack 2", a, 1);
    i2c_stop(); qwait();
    check("R3 first byte stored", mem[8'h10], 8'hA1);
    check("R4 second byte next reg", mem[8'h11], 8'hB2);
    check("R4 third byte next reg", mem[8'h12], 8'hC3);
    check("R3 one strobe per byte", we_count - c0, 3);
    check("R11 sda released after stop", sda_oe, 0);
  endtask

  task automatic t_wrong_addr();
    logic a; int c0 = we_count;
    i2c_start();
    send_byte({7'h2B, 1'b0}, a); check("R2 foreign address nack", a, 0);
    send_byte(8'h20, a);         check("R2 later byte nack", a, 0);
    send_byte(8'h99, a);         check("R2 third byte nack", a, 0);
    i2c_stop(); qwait();
    check("R2 no strobe", we_count - c0, 0);
    check("R2 register untouched", mem[8'h20], pat(8'h20));
  endtask

  task automatic t_read_burst();
    logic a; logic [7:0] d;
    set_ptr(8'h30, 1'b0);
    i2c_start();
    send_byte({DEV, 1'b1}, a); check("R1 read address ack", a, 1);
    recv_byte(1'b1, 1'b0, 0, 8'h0, d); check("R6 first read byte", d, pat(8'h30));
    recv_byte(1'b1, 1'b0, 0, 8'h0, d); check("R7 ack gives next byte", d, pat(8'h31));
    recv_byte(1'b0, 1'b0, 0, 8'h0, d); check("R7 third byte", d, pat(8'h32));
    qwait();
    check("R7 sda released after nack", sda_oe, 0);
    scl_m = 1'b1; qwait(); check("R7 no more data after nack", sda_bus, 1);
    scl_m = 1'b0; qwait();
    i2c_stop();
  endtask

  task automatic t_shared_ptr();
    logic a; logic [7:0] d;
    set_ptr(8'h60, 1'b1);
    i2c_start(); send_byte({DEV, 1'b1}, a);
    recv_byte(1'b1, 1'b0, 0, 8'h0, d); check("R4 read continues at pointer", d, pat(8'h60));
    recv_byte(1'b0, 1'b0, 0, 8'h0, d); check("R4 read next", d, pat(8'h61));
    i2c_stop();
    i2c_start(); send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, 1'b0, 0, 8'h0, d); check("R4 pointer kept across transactions", d, pat(8'h62));
    i2c_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    set_ptr(8'hFE, 1'b0);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    i2c_stop(); qwait();
    check("R8 write at FE", mem[8'hFE], 8'h11);
    check("R8 write at FF", mem[8'hFF], 8'h22);
    check("R8 write wraps to 00", mem[8'h00], 8'h33);
    set_ptr(8'hFF, 1'b0);
    i2c_start(); send_byte({DEV, 1'b1}, a);
    recv_byte(1'b1, 1'b0, 0, 8'h0, d); check("R8 read at FF", d, 8'h22);
    recv_byte(1'b0, 1'b0, 0, 8'h0, d); check("R8 read wraps to 00", d, 8'h33);
    i2c_stop();
  endtask

  task automatic t_abort();
    logic a; int c0;
    c0 = we_count;
    set_ptr(8'h40, 1'b0);
    send_bits(8'h0F, 4);
    i2c_stop(); qwait();
    check("R9 stop mid-byte no write", we_count - c0, 0);
    check("R9 register kept", mem[8'h40], pat(8'h40));
    set_ptr(8'h41, 1'b0);
    send_byte(8'h77, a); check("R9 clean byte after abort", a, 1);
    i2c_stop(); qwait();
    check("R9 next transaction writes", mem[8'h41], 8'h77);
    c0 = we_count;
    set_ptr(8'h44, 1'b0);
    send_bits(8'hFF, 3);
    i2c_start();
    send_byte({DEV, 1'b0}, a); check("R9 address after mid-byte start", a, 1);
    send_byte(8'h45, a);
    send_byte(8'h3C, a);
    i2c_stop(); qwait();
    check("R9 start mid-byte single write", we_count - c0, 1);
    check("R9 partial byte dropped", mem[8'h44], pat(8'h44));
    check("R9 write after restart", mem[8'h45], 8'h3C);
  endtask

  task automatic t_stable_read();
    logic a; logic [7:0] d;
    set_ptr(8'h50, 1'b0);
    i2c_start(); send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, 1'b1, 8'h50, 8'hEE, d);
    check("R10 byte held while sending", d, pat(8'h50));
    i2c_stop();
    set_ptr(8'h50, 1'b0);
    i2c_start(); send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, 1'b0, 0, 8'h0, d);
    check("R10 new value on next read", d, 8'hEE);
    i2c_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_burst();
    t_wrong_addr();
    t_read_burst();
    t_shared_ptr();
    t_wrap();
    t_abort();
    t_stable_read();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule